// File: doc/BRIEF.md
# Segment Descriptor Loader

This block loads one segment register of a protected-mode processor from a 16-bit selector. After a one-cycle `start`, it works out which descriptor table the selector points into and checks the descriptor's position against that table's limit. It then fetches the 8-byte descriptor as two 32-bit reads over a simple request/response memory port. The descriptor goes through the type, writability and presence rules. When every check passes, the decoded base, expanded limit, default-size flag and selector are written into one entry of a small segment cache.

When a check fails, the block reports a fault vector number and an error code, and it leaves the cache untouched. The stack segment has its own rules for null selectors, writability and non-present descriptors. Other segments accept a null selector and get an empty entry. Privilege comparisons, gates, task switching and non-protected modes are outside this block.

The cache has a registered read port, so the surrounding pipeline can look up any entry.

Top module: `seg_loader`

## Requirements
- R1: The table is picked by selector bit 2: the local table when the bit is 1, the global table when it is 0. The low word is read at table base + (selector with bits 2:0 cleared). The high word is read at that address + 4, and is requested only after the low word has been returned. Each read request lasts one cycle.
- R2: If (selector with bits 2:0 cleared) + 7 is greater than the chosen table limit, the block raises fault vector 13 with error code selector & 0xFFFC, and it issues no memory read.
- R3: A selector whose bits 15:2 are all zero is null. For a non-stack load it writes base 0, limit 0 and size flag 1, issues no read and raises no fault.
- R4: A null selector loaded as the stack segment raises fault vector 13 with error code selector & 0xFFFC.
- R5: A descriptor whose high-word bit 12 (S) is 0 raises fault vector 13.
- R6: A descriptor with high-word bit 11 = 1 (code) and bit 9 = 0 (not readable) raises fault vector 13, for both stack and non-stack loads.
- R7: For a stack load, a descriptor with bit 11 = 0 and bit 9 = 0 (read-only data) raises fault vector 13. A non-stack load of the same descriptor succeeds.
- R8: If high-word bit 15 (present) is 0 and no type fault applies, a stack load raises vector 12 and any other load raises vector 11. The error code is selector & 0xFFFC. Type faults take priority over presence.
- R9: On success, the base is {high[31:24], high[7:0], low[31:16]}, the 20-bit limit is {high[19:16], low[15:0]}, and the size flag is high bit 22.
- R10: When high bit 23 is 1, the stored limit is the 20-bit limit shifted left by 12 with bits 11:0 set to one.
- R11: A load that faults changes no cache entry.
- R12: Every accepted `start` produces exactly one single-cycle `done`. `fault_valid` is high only in that same cycle. `fault_code` and `fault_err` hold their values until the next fault.
- R13: A cache read returns the entry selected by `rd_idx` on the clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle load request, accepted when idle |
| sel_in | input | 16 | Selector to load |
| seg_idx | input | IDX_W | Target cache entry |
| is_stack | input | 1 | Load targets the stack segment |
| gtab_base | input | ADDR_W | Global table base address |
| gtab_limit | input | TLIM_W | Global table limit |
| ltab_base | input | ADDR_W | Local table base address |
| ltab_limit | input | TLIM_W | Local table limit |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Load finished (pulse) |
| fault_valid | output | 1 | Load faulted (pulse, with done) |
| fault_code | output | 8 | Fault vector: 13, 12 or 11 |
| fault_err | output | 16 | Fault error code |
| rd_idx | input | IDX_W | Cache read index |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached expanded limit |
| rd_big | output | 1 | Cached default-size flag |
| rd_sel | output | 16 | Cached selector |

## Verification
The bench uses six cache entries, 32-bit addresses and 16-bit table limits. The global table is sized for eight descriptors and the local table for three. With those sizes, the last legal entry and the first illegal entry of each table are only a few selectors apart, so the limit boundary can be tested from both sides. Memory returns data two cycles after each request, which tests that the second read waits for the first response.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;
  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_SS = 8'd12;
  localparam logic [7:0] VEC_NP = 8'd11;

  typedef enum logic [2:0] {
    LD_IDLE, LD_DECIDE, LD_WAIT_LO, LD_WAIT_HI, LD_EVAL
  } ld_state_t;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic        big;
    logic [15:0] sel;
  } seg_entry_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
) (
  input  logic [15:0]       sel,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_limit,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_limit,
  output logic              is_null,
  output logic              over_limit,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int EW = (TLIM_W > 16 ? TLIM_W : 16) + 1;

  logic [15:0]       offset;
  logic [EW-1:0]     last_byte;
  logic [EW-1:0]     lim_ext;
  logic [ADDR_W-1:0] tbase;

  always_comb begin
    offset     = {sel[15:3], 3'b000};
    is_null    = (sel[15:2] == 14'd0);
    tbase      = sel[2] ? ltab_base : gtab_base;
    lim_ext    = EW'(sel[2] ? ltab_limit : gtab_limit);
    last_byte  = EW'(offset) + EW'(7);
    over_limit = last_byte > lim_ext;
    desc_addr  = tbase + ADDR_W'(offset);
  end
endmodule

// File: rtl/seg_desc_eval.sv
module seg_desc_eval
  import seg_ld_pkg::*;
(
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  input  logic        stack_seg,
  output logic        fault,
  output logic [7:0]  fault_vec,
  output logic [31:0] base,
  output logic [31:0] limit,
  output logic        big
);
  logic        f_s, f_code, f_rw, f_pres, f_gran;
  logic [19:0] lim20;

  always_comb begin
    f_s    = hi_word[12];
    f_code = hi_word[11];
    f_rw   = hi_word[9];
    f_pres = hi_word[15];
    f_gran = hi_word[23];
    fault     = 1'b0;
    fault_vec = VEC_GP;
    if (!f_s || (f_code && !f_rw)) begin
      fault = 1'b1;
    end else if (stack_seg && !f_code && !f_rw) begin
      fault = 1'b1;
    end else if (!f_pres) begin
      fault     = 1'b1;
      fault_vec = stack_seg ? VEC_SS : VEC_NP;
    end
    base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    lim20 = {hi_word[19:16], lo_word[15:0]};
    limit = f_gran ? {lim20, 12'hFFF} : {12'h000, lim20};
    big   = hi_word[22];
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_ld_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  localparam int IDX_W = $clog2(NUM_SEGS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  seg_entry_t       wdata,
  input  logic [IDX_W-1:0] raddr,
  output seg_entry_t       rdata
);
  seg_entry_t mem [NUM_SEGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_ld_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int ADDR_W   = 32,
  parameter int TLIM_W   = 16,
  localparam int IDX_W = $clog2(NUM_SEGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       sel_in,
  input  logic [IDX_W-1:0]  seg_idx,
  input  logic              is_stack,
  input  logic [ADDR_W-1:0] gtab_base,
  input  logic [TLIM_W-1:0] gtab_limit,
  input  logic [ADDR_W-1:0] ltab_base,
  input  logic [TLIM_W-1:0] ltab_limit,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic              fault_valid,
  output logic [7:0]        fault_code,
  output logic [15:0]       fault_err,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_base,
  output logic [31:0]       rd_limit,
  output logic              rd_big,
  output logic [15:0]       rd_sel
);
  ld_state_t         state;
  logic [15:0]       sel_q;
  logic [IDX_W-1:0]  idx_q;
  logic              stk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       lo_q, hi_q;

  logic              dec_null, dec_over;
  logic [ADDR_W-1:0] dec_addr;
  logic              ev_fault;
  logic [7:0]        ev_vec;
  logic [31:0]       ev_base, ev_limit;
  logic              ev_big;

  logic              cache_we;
  seg_entry_t        cache_wdata;
  seg_entry_t        cache_rdata;
  logic              busy;
  logic [15:0]       err_code;

  seg_sel_decode #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) u_dec (
    .sel(sel_q), .gtab_base(gtab_base), .gtab_limit(gtab_limit),
    .ltab_base(ltab_base), .ltab_limit(ltab_limit),
    .is_null(dec_null), .over_limit(dec_over), .desc_addr(dec_addr)
  );

  seg_desc_eval u_eval (
    .lo_word(lo_q), .hi_word(hi_q), .stack_seg(stk_q),
    .fault(ev_fault), .fault_vec(ev_vec),
    .base(ev_base), .limit(ev_limit), .big(ev_big)
  );

  seg_cache #(.NUM_SEGS(NUM_SEGS)) u_cache (
    .clk(clk), .we(cache_we), .waddr(idx_q), .wdata(cache_wdata),
    .raddr(rd_idx), .rdata(cache_rdata)
  );

  assign busy     = (state != LD_IDLE);
  assign err_code = {sel_q[15:2], 2'b00};

  always_comb begin
    cache_we    = 1'b0;
    cache_wdata = '{base: 32'd0, limit: 32'd0, big: 1'b1, sel: sel_q};
    if (state == LD_DECIDE && dec_null && !stk_q) begin
      cache_we = 1'b1;
    end else if (state == LD_EVAL && !ev_fault) begin
      cache_we    = 1'b1;
      cache_wdata = '{base: ev_base, limit: ev_limit, big: ev_big, sel: sel_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= LD_IDLE;
      sel_q       <= '0;
      idx_q       <= '0;
      stk_q       <= 1'b0;
      addr_q      <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= '0;
      fault_err   <= '0;
    end else begin
      mem_rd_en   <= 1'b0;
      done        <= 1'b0;
      fault_valid <= 1'b0;
      unique case (state)
        LD_IDLE: if (start) begin
          sel_q <= sel_in;
          idx_q <= seg_idx;
          stk_q <= is_stack;
          state <= LD_DECIDE;
        end
        LD_DECIDE: begin
          if ((dec_null && stk_q) || (!dec_null && dec_over)) begin
            done        <= 1'b1;
            fault_valid <= 1'b1;
            fault_code  <= VEC_GP;
            fault_err   <= err_code;
            state       <= LD_IDLE;
          end else if (dec_null) begin
            done  <= 1'b1;
            state <= LD_IDLE;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= dec_addr;
            addr_q      <= dec_addr;
            state       <= LD_WAIT_LO;
          end
        end
        LD_WAIT_LO: if (mem_rvalid) begin
          lo_q        <= mem_rdata;
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= addr_q + ADDR_W'(4);
          state       <= LD_WAIT_HI;
        end
        LD_WAIT_HI: if (mem_rvalid) begin
          hi_q  <= mem_rdata;
          state <= LD_EVAL;
        end
        LD_EVAL: begin
          done <= 1'b1;
          if (ev_fault) begin
            fault_valid <= 1'b1;
            fault_code  <= ev_vec;
            fault_err   <= err_code;
          end
          state <= LD_IDLE;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  assign rd_base  = cache_rdata.base;
  assign rd_limit = cache_rdata.limit;
  assign rd_big   = cache_rdata.big;
  assign rd_sel   = cache_rdata.sel;
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       fault_valid,
  input logic [7:0] fault_code,
  input logic       mem_rd_en,
  input logic       cache_we,
  input logic       stk_q,
  input logic       busy
);
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> done); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en); // R1
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy); // R1
  AST_WRITE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    cache_we |=> (done && !fault_valid)); // R11
  AST_NP_NOT_STACK: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_code == 8'd11) |-> !stk_q); // R8
  AST_SS_IS_STACK: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_code == 8'd12) |-> stk_q); // R8
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_code == 8'd11 || fault_code == 8'd12 || fault_code == 8'd13)); // R8
endmodule

bind seg_loader seg_loader_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .fault_valid(fault_valid),
  .fault_code(fault_code), .mem_rd_en(mem_rd_en), .cache_we(cache_we),
  .stk_q(stk_q), .busy(busy)
);

// File: tb/seg_loader_bench.sv
module seg_loader_bench;
  localparam int NSEG = 6;
  localparam int IW   = $clog2(NSEG);
  localparam logic [31:0] GB = 32'h0001_0000;
  localparam logic [15:0] GL = 16'h003F;
  localparam logic [31:0] LB = 32'h0002_0000;
  localparam logic [15:0] LL = 16'h0017;

  logic clk = 0, rst = 1;
  always #2.5 clk = ~clk;

  logic start = 0, is_stack = 0, mem_rvalid = 0;
  logic [15:0] sel_in = 0;
  logic [IW-1:0] seg_idx = 0, rd_idx = 0;
  logic [31:0] mem_rdata = 0;
  logic mem_rd_en, done, fault_valid, rd_big;
  logic [31:0] mem_rd_addr, rd_base, rd_limit;
  logic [7:0] fault_code;
  logic [15:0] fault_err, rd_sel;

  seg_loader #(.NUM_SEGS(NSEG), .ADDR_W(32), .TLIM_W(16)) u_seg_loader (
    .clk(clk), .rst(rst), .start(start), .sel_in(sel_in), .seg_idx(seg_idx),
    .is_stack(is_stack), .gtab_base(GB), .gtab_limit(GL), .ltab_base(LB),
    .ltab_limit(LL), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_err(fault_err),
    .rd_idx(rd_idx), .rd_base(rd_base), .rd_limit(rd_limit), .rd_big(rd_big),
    .rd_sel(rd_sel)
  );

  int checks = 0, errors = 0;
  logic [31:0] sh_base [NSEG];
  logic [31:0] sh_lim  [NSEG];
  logic        sh_big  [NSEG];
  logic [15:0] sh_sel  [NSEG];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
      input bit g, input bit db, input bit p, input bit s, input logic [3:0] typ);
    return {b[31:24], g, db, 2'b00, l[19:16], p, 2'b00, s, typ, b[23:16]};
  endfunction

  // Behavioural expectation for one load
  task automatic model(input logic [15:0] sel, input bit stk, input logic [31:0] lo, hi,
      output int code, output int nrd, output logic [31:0] eaddr,
      output logic [31:0] eb, output logic [31:0] el, output bit ebig);
    int off, lim, tb, l20;
    off = sel & 16'hFFF8;
    lim = sel[2] ? int'(LL) : int'(GL);
    tb  = sel[2] ? int'(LB) : int'(GB);
    eaddr = 32'(tb + off);
    code = 0; nrd = 0; eb = 0; el = 0; ebig = 1;
    if ((sel & 16'hFFFC) == 0) begin
      if (stk) code = 13;
    end else if (off + 7 > lim) begin
      code = 13;
    end else begin
      nrd = 2;
      if (!hi[12] || (hi[11] && !hi[9])) code = 13;
      else if (stk && !hi[11] && !hi[9]) code = 13;
      else if (!hi[15]) code = stk ? 12 : 11;
      else begin
        eb = {hi[31:24], hi[7:0], lo[31:16]};
        l20 = {hi[19:16], lo[15:0]};
        el = hi[23] ? 32'((l20 * 4096) + 4095) : 32'(l20);
        ebig = hi[22];
      end
    end
  endtask

  task automatic check_entry(input int idx, input string req);
    @(negedge clk); rd_idx = IW'(idx);
    @(negedge clk);
    chk(rd_base == sh_base[idx], {req, " base"}, rd_base, sh_base[idx]);
    chk(rd_limit == sh_lim[idx], {req, " limit"}, rd_limit, sh_lim[idx]);
    chk(rd_big == sh_big[idx], {req, " size"}, rd_big, sh_big[idx]);
    chk(rd_sel == sh_sel[idx], {req, " selector"}, rd_sel, sh_sel[idx]);
  endtask

  task automatic run(input logic [15:0] sel, input int idx, input bit stk,
      input logic [31:0] lo, input logic [31:0] hi, input string req);
    int code, nrd, cnt, seen;
    logic [31:0] eaddr, eb, el, raddr;
    bit ebig, got, fv;
    logic [7:0] fc;
    logic [15:0] fe;
    model(sel, stk, lo, hi, code, nrd, eaddr, eb, el, ebig);
    @(negedge clk);
    start = 1; sel_in = sel; seg_idx = IW'(idx); is_stack = stk;
    @(negedge clk);
    start = 0;
    seen = 0; cnt = -1; got = 0; raddr = 0; fv = 0; fc = 0; fe = 0;
    for (int c = 0; c < 40 && !got; c++) begin
      mem_rvalid = 0;
      if (cnt == 0) begin
        mem_rvalid = 1;
        mem_rdata = (raddr == eaddr) ? lo : (raddr == eaddr + 4) ? hi : 32'hDEAD_BEEF;
        cnt = -1;
      end else if (cnt > 0) cnt--;
      if (mem_rd_en) begin
        chk(mem_rd_addr == (seen == 0 ? eaddr : eaddr + 4), {req, " R1 read address"},
            mem_rd_addr, seen == 0 ? eaddr : eaddr + 4);
        raddr = mem_rd_addr; seen++; cnt = 1;
      end
      if (done) begin got = 1; fv = fault_valid; fc = fault_code; fe = fault_err; end
      else @(negedge clk);
    end
    mem_rvalid = 0;
    chk(got, {req, " R12 done seen"}, got, 1);
    chk(seen == nrd, {req, " read count"}, seen, nrd);
    chk(fv == (code != 0), {req, " fault flag"}, fv, code != 0);
    if (code != 0) begin
      chk(fc == 8'(code), {req, " fault vector"}, fc, code);
      chk(fe == (sel & 16'hFFFC), {req, " error code"}, fe, sel & 16'hFFFC);
    end else begin
      sh_base[idx] = eb; sh_lim[idx] = el; sh_big[idx] = ebig; sh_sel[idx] = sel;
    end
    @(negedge clk);
    chk(!done && !fault_valid, {req, " R12 single pulse"}, {done, fault_valid}, 0);
    check_entry(idx, code != 0 ? {req, " R11 cache unchanged"} : {req, " R13 cache read"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !fault_valid && !mem_rd_en, "reset outputs idle", {done, fault_valid, mem_rd_en}, 0);
    rst = 0;
    // R3: null selectors fill every entry
    for (int i = 0; i < NSEG; i++) run(16'h0003, i, 0, 0, 0, "R3 null non-stack");
    // R4: null into the stack segment
    run(16'h0002, 2, 1, 0, 0, "R4 null stack");
    // R9: global table writable data, byte-granular limit
    run(16'h0008, 0, 0, mk_lo(32'hABCD5678, 20'h51234),
        mk_hi(32'hABCD5678, 20'h51234, 0, 1, 1, 1, 4'h2), "R9 fields");
    // R10 + R1: local table readable code, page-granular limit
    run(16'h000C, 1, 0, mk_lo(32'h1020_3040, 20'h000FF),
        mk_hi(32'h1020_3040, 20'h000FF, 1, 0, 1, 1, 4'hA), "R10 granularity");
    // R2: last legal and first illegal entry of each table
    run(16'h0038, 3, 0, mk_lo(32'h0, 20'h1), mk_hi(32'h0, 20'h1, 0, 1, 1, 1, 4'h2), "R2 last legal global");
    run(16'h0040, 3, 0, 0, 0, "R2 global over limit");
    run(16'h0014, 4, 0, mk_lo(32'h5, 20'h7), mk_hi(32'h5, 20'h7, 1, 1, 1, 1, 4'h2), "R2 last legal local");
    run(16'h001F, 4, 1, 0, 0, "R2 local over limit");
    // R5: system descriptor
    run(16'h0010, 0, 0, 0, mk_hi(32'h0, 20'h0, 0, 0, 1, 0, 4'h2), "R5 system descriptor");
    // R6: execute-only code, both flavours
    run(16'h0018, 1, 0, 0, mk_hi(32'h0, 20'h0, 0, 1, 1, 1, 4'h8), "R6 exec-only");
    run(16'h0018, 2, 1, 0, mk_hi(32'h0, 20'h0, 0, 1, 1, 1, 4'h8), "R6 exec-only stack");
    // R7: read-only data
    run(16'h0020, 2, 1, mk_lo(32'h9, 20'h9), mk_hi(32'h9, 20'h9, 0, 1, 1, 1, 4'h0), "R7 read-only stack");
    run(16'h0020, 5, 0, mk_lo(32'h9, 20'h9), mk_hi(32'h9, 20'h9, 0, 1, 1, 1, 4'h0), "R7 read-only data");
    run(16'h0028, 2, 1, mk_lo(32'hF00, 20'hFFFFF), mk_hi(32'hF00, 20'hFFFFF, 1, 1, 1, 1, 4'h2), "R7 writable stack");
    // R8: not present and priority
    run(16'h0030, 2, 1, 0, mk_hi(32'h0, 20'h0, 0, 1, 0, 1, 4'h2), "R8 stack not present");
    run(16'h0033, 4, 0, 0, mk_hi(32'h0, 20'h0, 0, 1, 0, 1, 4'h2), "R8 not present");
    run(16'h0030, 4, 0, 0, mk_hi(32'h0, 20'h0, 0, 1, 0, 0, 4'h2), "R8 type before presence");
    // R11: every entry still matches after the faults above
    for (int i = 0; i < NSEG; i++) check_entry(i, "R11 final cache");
    summary();
  end
endmodule